// File: doc/BRIEF.md
# SAR Converter Read Controller with Data-Line Ready Detect

This block runs an 18-bit successive-approximation converter from the host side over a three-wire serial link. The link has a convert line, a serial clock and one data line. A start request makes the controller raise the convert line for a short, fixed pulse and then pull it low again. The convert line then stays low for the whole of the longest possible conversion. The converter leaves its data output undriven while it converts, so an external pull-up holds the line high. When the converter finishes, it drives the line low, and the controller takes that low level as its ready interrupt.

After the ready indication, the controller produces serial clock pulses. On each falling edge the converter presents the next bit. The controller captures that bit half a clock period later, at the rising edge that follows. The word arrives MSB first. An optional extra pulse after the last bit makes the converter release the data line. The word then appears on a parallel output with a one-cycle valid strobe. If no ready indication arrives within a bounded window, a one-cycle timeout pulse is raised and the controller goes back to idle.

The data line passes through a two-flop synchroniser. Each serial clock phase is therefore set longer than the synchroniser delay plus the converter's output delay.

Top module: `sar_busy_reader`

## Requirements
- R1: A cycle with `start_i` high while the controller is idle makes `adc_cnv_o` and `busy_o` go high at the next clock edge.
- R2: `adc_cnv_o` stays high for exactly CNV_HIGH_CYC clocks. It then stays low until the transfer ends.
- R3: The controller ignores the data line during the convert pulse and for CONV_MAX_CYC clocks after the convert line falls. No serial clock edge occurs in that time, even if the line is already low.
- R4: After that wait, a low level on the synchronised data line starts the read.
- R5: The read produces DATA_W falling serial clock edges. Each one is followed by a rising edge that captures one bit. The first captured bit becomes `result_o[DATA_W-1]` and the last becomes `result_o[0]`.
- R6: The serial clock idles high. During a read, each of its high and low phases lasts at least SCK_HALF_CYC clocks.
- R7: With EXTRA_CLK=1, one more falling and rising pair follows the last capture before the transfer ends. The converter releases the data line on that falling edge, so each transfer has DATA_W+1 falling edges.
- R8: `result_valid_o` is high for exactly one cycle per completed read, together with the new `result_o`. `busy_o` is low in that cycle.
- R9: If the synchronised data line stays high for READY_TIMEOUT_CYC clocks after the wait, `timeout_o` pulses for one cycle. No serial clock runs, no valid strobe is produced, and the controller returns to idle.
- R10: `start_i` has no effect while `busy_o` is high. No second convert pulse occurs during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and read |
| adc_sdo_i | input | 1 | Converter serial data; pulled high while undriven |
| adc_cnv_o | output | 1 | Convert line to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter, idle high |
| busy_o | output | 1 | Transfer in progress |
| result_o | output | DATA_W | Last converted word |
| result_valid_o | output | 1 | One-cycle strobe marking a new `result_o` |
| timeout_o | output | 1 | One-cycle pulse when no ready indication arrives |

## Verification
The hardest case to reach from the ports is a converter that finishes before the controller's maximum-conversion wait has ended. The data line then goes low while the controller must still ignore it. A behavioural converter model in the bench is set to answer early for some transfers and late for others. The bench measures the gap from the convert line falling to the first serial clock edge. A start request is also injected in the middle of a read, and the model withholds its answer entirely on one transfer to force the timeout path.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_HOLD,
    ST_WATCH,
    ST_READ
  } rd_state_t;
endpackage

// File: rtl/sar_rd_sync.sv
module sar_rd_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= {STAGES{RST_VAL}};
        else     pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= {STAGES{RST_VAL}};
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_rd_timer.sv
module sar_rd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sar_rd_shifter.sv
module sar_rd_shifter #(
  parameter int DATA_W   = 18,
  parameter int HALF_CYC = 4,
  parameter bit EXTRA_CLK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              sdo_i,
  output logic              sck_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int N_PULSE = DATA_W + (EXTRA_CLK ? 1 : 0);
  localparam int N_TOG   = 2 * N_PULSE;
  localparam int TOG_W   = $clog2(N_TOG + 1);
  localparam int PH_W    = $clog2(HALF_CYC + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYC - 1);
  localparam logic [TOG_W-1:0] TOG_LAST = TOG_W'(N_TOG - 1);
  localparam logic [TOG_W-1:0] CAP_END  = TOG_W'(2 * DATA_W);

  logic              active_q;
  logic              sck_q;
  logic              done_q;
  logic [PH_W-1:0]   ph_q;
  logic [TOG_W-1:0]  tog_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sck_q    <= 1'b1;
      done_q   <= 1'b0;
      ph_q     <= '0;
      tog_q    <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          ph_q     <= '0;
          tog_q    <= '0;
        end
      end else if (ph_q == PH_LAST) begin
        ph_q  <= '0;
        sck_q <= ~sck_q;
        tog_q <= tog_q + 1'b1;
        // odd toggles are rising edges; capture only for the data bits
        if (tog_q[0] && (tog_q < CAP_END))
          data_q <= {data_q[DATA_W-2:0], sdo_i};
        if (tog_q == TOG_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/sar_busy_reader.sv
module sar_busy_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W            = 18,
  parameter int CNV_HIGH_CYC      = 4,
  parameter int CONV_MAX_CYC      = 40,
  parameter int READY_TIMEOUT_CYC = 100,
  parameter int SCK_HALF_CYC      = 4,
  parameter bit EXTRA_CLK         = 1'b1,
  parameter int SYNC_STAGES       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              adc_sdo_i,
  output logic              adc_cnv_o,
  output logic              adc_sck_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              timeout_o
);
  localparam int MAX_AB  = (CNV_HIGH_CYC > CONV_MAX_CYC) ? CNV_HIGH_CYC : CONV_MAX_CYC;
  localparam int TMR_MAX = (MAX_AB > READY_TIMEOUT_CYC) ? MAX_AB : READY_TIMEOUT_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  rd_state_t         state_q, state_d;
  logic              cnv_q;
  logic              vld_q;
  logic              tmo_q;
  logic [DATA_W-1:0] res_q;

  logic              sdo_s;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              rd_go;
  logic              sh_done;
  logic [DATA_W-1:0] sh_data;

  sar_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(adc_sdo_i), .q_o(sdo_s)
  );

  sar_rd_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  sar_rd_shifter #(
    .DATA_W(DATA_W), .HALF_CYC(SCK_HALF_CYC), .EXTRA_CLK(EXTRA_CLK)
  ) u_shift (
    .clk(clk), .rst(rst), .go_i(rd_go), .sdo_i(sdo_s),
    .sck_o(adc_sck_o), .done_o(sh_done), .data_o(sh_data)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rd_go    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CNV_HIGH_CYC - 1);
        state_d  = ST_CNV;
      end
      ST_CNV: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CONV_MAX_CYC - 1);
        state_d  = ST_HOLD;
      end
      ST_HOLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(READY_TIMEOUT_CYC - 1);
        state_d  = ST_WATCH;
      end
      ST_WATCH: begin
        if (!sdo_s) begin
          rd_go   = 1'b1;
          state_d = ST_READ;
        end else if (tmr_exp) begin
          state_d = ST_IDLE;
        end
      end
      ST_READ: if (sh_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnv_q   <= 1'b0;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      vld_q   <= sh_done;
      tmo_q   <= (state_q == ST_WATCH) && sdo_s && tmr_exp;
      if (sh_done) res_q <= sh_data;
      if (state_q == ST_IDLE && start_i)   cnv_q <= 1'b1;
      else if (state_q == ST_CNV && tmr_exp) cnv_q <= 1'b0;
    end
  end

  assign adc_cnv_o      = cnv_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign result_o       = res_q;
  assign result_valid_o = vld_q;
  assign timeout_o      = tmo_q;
endmodule

// File: rtl/sar_busy_reader_chk.sv
module sar_busy_reader_chk #(
  parameter int CNV_HIGH_CYC = 4,
  parameter int SCK_HALF_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic adc_cnv_o,
  input logic adc_sck_o,
  input logic busy_o,
  input logic result_valid_o,
  input logic timeout_o
);
  logic [15:0] hi_cnt_q;
  logic [15:0] run_q;
  logic        last_sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q   <= '0;
      run_q      <= '0;
      last_sck_q <= 1'b1;
    end else begin
      hi_cnt_q   <= adc_cnv_o ? ((hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 1'b1) : '0;
      last_sck_q <= adc_sck_o;
      if (adc_sck_o != last_sck_q) run_q <= 16'd1;
      else if (run_q != 16'hFFFF)  run_q <= run_q + 1'b1;
    end
  end

  a_r1_cnv_from_idle_start: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cnv_o) |-> ($past(start_i) && !$past(busy_o)));

  a_r2_cnv_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cnv_o) |-> (hi_cnt_q == 16'(CNV_HIGH_CYC)));

  a_r3_sck_quiet_in_convert: assert property (@(posedge clk) disable iff (rst)
    (adc_cnv_o || !busy_o) |-> adc_sck_o);

  a_r6_sck_phase_min: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (adc_sck_o != last_sck_q)) |-> (run_q >= 16'(SCK_HALF_CYC)));

  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  a_r8_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (!busy_o && !timeout_o));

  a_r9_timeout_single_idle: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!busy_o && adc_sck_o)) ;

  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);
endmodule

bind sar_busy_reader sar_busy_reader_chk #(
  .CNV_HIGH_CYC(CNV_HIGH_CYC),
  .SCK_HALF_CYC(SCK_HALF_CYC)
) u_chk (
  .clk(clk),
  .rst(rst),
  .start_i(start_i),
  .adc_cnv_o(adc_cnv_o),
  .adc_sck_o(adc_sck_o),
  .busy_o(busy_o),
  .result_valid_o(result_valid_o),
  .timeout_o(timeout_o)
);

// File: tb/sar_busy_reader_bench.sv
module sar_busy_reader_bench;
  localparam int DW       = 18;
  localparam int CNV_HI   = 4;
  localparam int CONV_MAX = 40;
  localparam int TMO      = 100;
  localparam int HALF     = 4;
  localparam int T_MIN    = 10;   // converter's shortest conversion, model side

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          sdo_m = 1'b1;
  logic          adc_cnv_o, adc_sck_o, busy_o, result_valid_o, timeout_o;
  logic [DW-1:0] result_o;

  always #2.5 clk = ~clk;   // 200 MHz

  sar_busy_reader #(
    .DATA_W(DW), .CNV_HIGH_CYC(CNV_HI), .CONV_MAX_CYC(CONV_MAX),
    .READY_TIMEOUT_CYC(TMO), .SCK_HALF_CYC(HALF), .EXTRA_CLK(1'b1),
    .SYNC_STAGES(2)
  ) u_sar_busy_reader (
    .clk(clk), .rst(rst), .start_i(start_i), .adc_sdo_i(sdo_m),
    .adc_cnv_o(adc_cnv_o), .adc_sck_o(adc_sck_o), .busy_o(busy_o),
    .result_o(result_o), .result_valid_o(result_valid_o), .timeout_o(timeout_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- converter model ----------------
  logic [DW-1:0] m_word = '0;
  int  m_tconv = 30;
  bit  m_respond = 1'b1;
  int  cyc = 0;
  logic cnv_p = 1'b0, sck_p = 1'b1;
  int  conv_left = 0;
  bit  drv = 1'b0;
  int  idx = 0;
  int  hi_cnt = 0;
  int  cnv_hi_width = 0;
  int  cnv_fall_cyc = 0;
  int  first_fall_cyc = -1;
  int  nfall = 0;
  int  cnv_rises = 0;
  int  rise_in_conv = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cnv_p <= adc_cnv_o;
    sck_p <= adc_sck_o;
    if (rst) begin
      sdo_m <= 1'b1;
      conv_left = 0;
      drv = 1'b0;
    end else begin
      if (adc_cnv_o && !cnv_p) begin
        cnv_rises++;
        if (conv_left > 0) rise_in_conv++;
        sdo_m <= 1'b1;
        drv = 1'b0;
        hi_cnt = 0;
        conv_left = m_respond ? m_tconv : 0;
      end
      if (adc_cnv_o) hi_cnt++;
      if (!adc_cnv_o && cnv_p) begin
        cnv_fall_cyc = cyc;
        cnv_hi_width = hi_cnt;
      end
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) begin
          sdo_m <= 1'b0;
          drv = 1'b1;
          idx = 0;
        end
      end
      if (sck_p && !adc_sck_o) begin
        nfall++;
        if (first_fall_cyc < 0) first_fall_cyc = cyc;
        if (drv) begin
          if (idx < DW) begin
            sdo_m <= m_word[DW-1-idx];
            idx++;
          end else begin
            sdo_m <= 1'b1;
            drv = 1'b0;
          end
        end
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [DW-1:0] exp_q[$];
  int  vcount = 0;
  int  tmo_cnt = 0;
  int  run = 0;
  int  min_run = 1000;
  logic sck_n = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (result_valid_o) begin
        vcount++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected valid", result_o, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(result_o == e, "R5 result word", result_o, e);
        end
      end
      if (timeout_o) tmo_cnt++;
      if (adc_sck_o != sck_n) begin
        if (busy_o && run < min_run) min_run = run;
        run = 1;
      end else begin
        run++;
      end
      sck_n = adc_sck_o;
    end
  end

  // ---------------- driver ----------------
  task automatic do_xfer(input logic [DW-1:0] w, input int tconv,
                         input bit respond, input bit poke);
    int rises0;
    m_word = w;
    m_tconv = tconv;
    m_respond = respond;
    nfall = 0;
    first_fall_cyc = -1;
    vcount = 0;
    tmo_cnt = 0;
    min_run = 1000;
    rises0 = cnv_rises;
    if (respond) exp_q.push_back(w);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(adc_cnv_o && busy_o, "R1 convert and busy after start", {adc_cnv_o, busy_o}, 2'b11);
    if (poke) begin
      repeat (80) @(negedge clk);
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cnv_hi_width == CNV_HI, "R2 convert pulse width", cnv_hi_width, CNV_HI);
    chk(cnv_hi_width < T_MIN, "R2 convert low before min conversion", cnv_hi_width, T_MIN);
    chk(rise_in_conv == 0, "R2 convert held low through conversion", rise_in_conv, 0);
    chk(cnv_rises - rises0 == 1, "R10 one convert pulse per transfer", cnv_rises - rises0, 1);
    chk(!adc_cnv_o && adc_sck_o, "R6 idle levels after transfer", {adc_cnv_o, adc_sck_o}, 2'b01);
    if (respond) begin
      chk(vcount == 1, "R8 one valid strobe", vcount, 1);
      chk(nfall == DW + 1, "R7 falling edges incl trailing", nfall, DW + 1);
      chk(sdo_m == 1'b1, "R7 data line released", sdo_m, 1);
      chk(first_fall_cyc - cnv_fall_cyc >= CONV_MAX, "R3 no clock before max conversion",
          first_fall_cyc - cnv_fall_cyc, CONV_MAX);
      chk(min_run >= HALF, "R6 serial clock phase width", min_run, HALF);
      chk(tmo_cnt == 0, "R4 ready seen, no timeout", tmo_cnt, 0);
    end else begin
      chk(tmo_cnt == 1, "R9 timeout pulse", tmo_cnt, 1);
      chk(vcount == 0, "R9 no valid on timeout", vcount, 0);
      chk(nfall == 0, "R9 no serial clock on timeout", nfall, 0);
    end
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!adc_cnv_o && adc_sck_o && !busy_o && !result_valid_o && !timeout_o,
        "R6 reset state", {adc_cnv_o, adc_sck_o, busy_o, result_valid_o, timeout_o}, 5'b01000);
    do_xfer(18'h3FFFF, 30, 1'b1, 1'b0);   // early ready, all ones
    do_xfer(18'h00000, 30, 1'b1, 1'b0);   // all zeros
    do_xfer(18'h2AAAA, 60, 1'b1, 1'b0);   // ready arrives inside the watch window (R4)
    do_xfer(18'h15555, 30, 1'b1, 1'b1);   // start poked mid-read (R10)
    do_xfer(18'h00000, 30, 1'b0, 1'b0);   // converter silent (R9)
    do_xfer(18'h1A5C3, 45, 1'b1, 1'b0);   // recovery after timeout
    do_xfer(18'h20001, 30, 1'b1, 1'b0);   // MSB and LSB only (R5)
    chk(result_o == 18'h20001, "R8 result held after strobe", result_o, 18'h20001);
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    wrap_up();
  end
endmodule